// File: doc/BRIEF.md
# Micro-threaded DRAM core model

This block is a cycle-based, synthesizable model of a DRAM storage core split into sixteen independent banks. Banks form four quadrants, and each quadrant has its own row timer and its own column timer. Quadrants therefore accept commands independently. A single command port carries one command per cycle: an activate (open a row), a column read or a column write. Commands that break the timing rules, address a bank with no open row, or would collide on a data group are dropped. Each dropped command raises a one-cycle error pulse.

Read data leaves on two narrow data groups: lane A for even banks and lane B for odd banks. One column access is 8 bytes. It goes out as half-width beats over half of the column interval. Within one lane, an upper-quadrant burst is delayed by one half-window less one cycle. A lower-quadrant read followed one cycle later by an upper-quadrant read on the same lane therefore fills the lane back to back. Each activated row holds 16 bytes, which is two columns.

Top module: `mtc_core`

## Requirements
- R1: After reset, every storage word reads as zero, no bank has an open row, and `err_o`, `dqa_vld_o` and `dqb_vld_o` are low.
- R2: Bank bit 0 picks the lane (0 = lane A, 1 = lane B) and bank bit 3 picks upper (1) or lower (0). The quadrant is {bit 3, bit 0}.
- R3: Once an activate is accepted in a quadrant, any activate to a bank of that quadrant is rejected for the next T_RR-1 cycles. One exactly T_RR cycles later is accepted. Activates to other quadrants are unaffected.
- R4: Once a column command is accepted in a quadrant, any column command to a bank of that quadrant is rejected for the next T_CC-1 cycles. One exactly T_CC cycles later is accepted. Other quadrants are unaffected.
- R5: A read or write to a bank with no open row is rejected.
- R6: A rejected command changes no storage, no open row and no timer. `err_o` is high in the cycle after it and low after an accepted command or an idle cycle. Op code 11 is always rejected (00 activate, 01 read, 10 write).
- R7: A lower-quadrant read puts T_CC/2 beats on its lane, starting RD_LAT cycles after the command cycle. Beat j carries bits [32j+31:32j] of the 64-bit column, and the lane's valid is high for exactly those cycles.
- R8: An upper-quadrant read starts its burst RD_LAT+T_CC/2-1 cycles after the command cycle. A lower read followed one cycle later by an upper read on the same lane gives one unbroken run of beats.
- R9: A read whose beats would land in any cycle already holding a scheduled beat of the same lane is rejected.
- R10: A write stores its 64-bit data in the command cycle, at the open row and the column given by `cmd_col_i`. A later read of that location returns it.
- R11: An activate to a bank that already has an open row switches it to the new row. Later column commands address the new row, and the old row's contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 00 activate, 01 read, 10 write, 11 reserved |
| cmd_bank_i | input | 4 | Target bank |
| cmd_row_i | input | ROW_AW | Row for an activate |
| cmd_col_i | input | COL_AW | Column for a read or write |
| cmd_wdata_i | input | COL_BITS | Write data, taken in the command cycle |
| err_o | output | 1 | Pulse one cycle after a rejected command |
| dqa_o | output | BEAT_W | Lane A beat (even banks) |
| dqa_vld_o | output | 1 | Lane A beat valid |
| dqb_o | output | BEAT_W | Lane B beat (odd banks) |
| dqb_vld_o | output | 1 | Lane B beat valid |

## Verification
A table of back-to-back commands covers the timing rules. It places same-quadrant activates and column commands at one cycle, at T_RR-1 or T_CC-1 cycles, and at the exact boundary, interleaved with commands to the other three quadrants. This separates quadrant-wide tracking from bank-wide or device-wide tracking. Directed reads then check the following:
- A single lower read checks lane choice, beat order and latency.
- A lower/upper pair on one lane checks the seamless interleave.
- An upper read followed by a clashing lower read, then a later lower read that fits, checks slot collision against the bare latency rule.
- Reading back a word whose write was rejected, and reading after a row switch or a second reset, checks that dropped commands and reset leave storage as required.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int NUM_BANKS = 16;
    localparam int NUM_QUADS = 4;
    localparam int BANK_W    = 4;
    localparam int QUAD_W    = 2;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_RSV = 2'b11
    } mtc_op_e;

    typedef struct packed {
        logic                vld;
        mtc_op_e             op;
        logic [BANK_W-1:0]   bank;
    } mtc_cmd_t;

    // lane select: even banks on lane A, odd banks on lane B
    function automatic logic lane_of(input logic [BANK_W-1:0] b);
        return b[0];
    endfunction

    function automatic logic upper_of(input logic [BANK_W-1:0] b);
        return b[3];
    endfunction

    function automatic logic [QUAD_W-1:0] quad_of(input logic [BANK_W-1:0] b);
        return {b[3], b[0]};
    endfunction

endpackage

// File: rtl/mtc_quad_ctrl.sv
module mtc_quad_ctrl #(
    parameter int T_RR = 4,
    parameter int T_CC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic act_fire_i,
    input  logic col_fire_i,
    output logic row_busy_o,
    output logic col_busy_o
);
    localparam int RR_W = $clog2(T_RR + 1);
    localparam int CC_W = $clog2(T_CC + 1);

    logic [RR_W-1:0] rr_cnt;
    logic [CC_W-1:0] cc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_cnt <= '0;
        end else if (act_fire_i) begin
            rr_cnt <= RR_W'(T_RR - 1);
        end else if (rr_cnt != '0) begin
            rr_cnt <= rr_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_cnt <= '0;
        end else if (col_fire_i) begin
            cc_cnt <= CC_W'(T_CC - 1);
        end else if (cc_cnt != '0) begin
            cc_cnt <= cc_cnt - 1'b1;
        end
    end

    assign row_busy_o = (rr_cnt != '0);
    assign col_busy_o = (cc_cnt != '0);

    assert_act_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        act_fire_i |-> !row_busy_o);

    assert_act_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (act_fire_i && (T_RR > 1)) |=> row_busy_o);

    assert_col_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        col_fire_i |-> !col_busy_o);

endmodule

// File: rtl/mtc_bank.sv
module mtc_bank #(
    parameter int N_ROWS   = 4,
    parameter int COLS     = 2,
    parameter int COL_BITS = 64,
    parameter int ROW_AW   = 2,
    parameter int COL_AW   = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                act_i,
    input  logic [ROW_AW-1:0]   row_i,
    input  logic                wr_i,
    input  logic [COL_AW-1:0]   col_i,
    input  logic [COL_BITS-1:0] wdata_i,
    output logic                open_o,
    output logic [COL_BITS-1:0] rdata_o
);
    localparam int WORDS = N_ROWS * COLS;

    logic [COL_BITS-1:0] mem [WORDS];
    logic [ROW_AW-1:0]   open_row;
    logic                open_q;
    int                  idx;

    always_comb begin
        idx = int'(open_row) * COLS + int'(col_i);
        if (idx >= WORDS) idx = WORDS - 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            open_row <= '0;
        end else if (act_i) begin
            open_q   <= 1'b1;
            open_row <= row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (wr_i) begin
            mem[idx] <= wdata_i;
        end
    end

    assign open_o  = open_q;
    assign rdata_o = mem[idx];

    assert_col_open_R5: assert property (@(posedge clk) disable iff (rst)
        wr_i |-> open_o);

    assert_act_opens_R11: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (open_o && open_row == $past(row_i)));

endmodule

// File: rtl/mtc_dq_lane.sv
module mtc_dq_lane #(
    parameter int RD_LAT = 3,
    parameter int HALF   = 2,
    parameter int BEAT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push_i,
    input  logic                   upper_i,
    input  logic [HALF*BEAT_W-1:0] data_i,
    output logic                   clash_o,
    output logic [BEAT_W-1:0]      dq_o,
    output logic                   vld_o
);
    // slot k reaches the output k edges after it is written
    localparam int DEPTH   = RD_LAT + 2 * HALF;
    localparam int LO_BASE = RD_LAT - 1;
    localparam int UP_BASE = RD_LAT + HALF - 2;

    logic              vld_q [DEPTH];
    logic [BEAT_W-1:0] dat_q [DEPTH];
    int                base_idx;

    always_comb begin
        base_idx = upper_i ? UP_BASE : LO_BASE;
        clash_o  = 1'b0;
        for (int j = 0; j < HALF; j++) begin
            if (vld_q[base_idx + j + 1]) clash_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                vld_q[k] <= 1'b0;
                dat_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                vld_q[k] <= vld_q[k+1];
                dat_q[k] <= dat_q[k+1];
            end
            vld_q[DEPTH-1] <= 1'b0;
            dat_q[DEPTH-1] <= '0;
            if (push_i) begin
                for (int j = 0; j < HALF; j++) begin
                    vld_q[base_idx + j] <= 1'b1;
                    dat_q[base_idx + j] <= data_i[j*BEAT_W +: BEAT_W];
                end
            end
        end
    end

    assign dq_o  = dat_q[0];
    assign vld_o = vld_q[0];

    assert_lane_clash_R9: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !clash_o);

endmodule

// File: rtl/mtc_core.sv
module mtc_core #(
    parameter int N_ROWS    = 4,
    parameter int COL_BYTES = 8,
    parameter int ROW_BYTES = 16,
    parameter int T_RR      = 4,
    parameter int T_CC      = 4,
    parameter int RD_LAT    = 3,
    localparam int COLS     = ROW_BYTES / COL_BYTES,
    localparam int COL_BITS = COL_BYTES * 8,
    localparam int HALF     = T_CC / 2,
    localparam int BEAT_W   = COL_BITS / HALF,
    localparam int ROW_AW   = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
    localparam int COL_AW   = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_vld_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [3:0]          cmd_bank_i,
    input  logic [ROW_AW-1:0]   cmd_row_i,
    input  logic [COL_AW-1:0]   cmd_col_i,
    input  logic [COL_BITS-1:0] cmd_wdata_i,
    output logic                err_o,
    output logic [BEAT_W-1:0]   dqa_o,
    output logic                dqa_vld_o,
    output logic [BEAT_W-1:0]   dqb_o,
    output logic                dqb_vld_o
);
    import mtc_pkg::*;

    mtc_cmd_t            cmd;
    logic [QUAD_W-1:0]   cq;
    logic                c_lane;
    logic                c_upper;

    logic [NUM_QUADS-1:0] row_busy, col_busy, act_fire, col_fire;
    logic [NUM_BANKS-1:0] open_b, act_b, wr_b;
    logic [COL_BITS-1:0]  rdata_b [NUM_BANKS];
    logic [1:0]           clash, push;
    logic [BEAT_W-1:0]    dq_l [2];
    logic [1:0]           vld_l;

    logic act_ok, col_ok, rd_ok, wr_ok, err_q;

    always_comb begin
        cmd.vld  = cmd_vld_i;
        cmd.op   = mtc_op_e'(cmd_op_i);
        cmd.bank = cmd_bank_i;
        cq       = quad_of(cmd.bank);
        c_lane   = lane_of(cmd.bank);
        c_upper  = upper_of(cmd.bank);
    end

    always_comb begin
        act_ok = cmd.vld && (cmd.op == OP_ACT) && !row_busy[cq];
        col_ok = cmd.vld && ((cmd.op == OP_RD) || (cmd.op == OP_WR))
                 && open_b[cmd.bank] && !col_busy[cq];
        rd_ok  = col_ok && (cmd.op == OP_RD) && !clash[c_lane];
        wr_ok  = col_ok && (cmd.op == OP_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cmd.vld && !(act_ok || rd_ok || wr_ok);
    end
    assign err_o = err_q;

    for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
        assign act_fire[q] = act_ok && (cq == QUAD_W'(q));
        assign col_fire[q] = (rd_ok || wr_ok) && (cq == QUAD_W'(q));
        mtc_quad_ctrl #(.T_RR(T_RR), .T_CC(T_CC)) quad_i (
            .clk        (clk),
            .rst        (rst),
            .act_fire_i (act_fire[q]),
            .col_fire_i (col_fire[q]),
            .row_busy_o (row_busy[q]),
            .col_busy_o (col_busy[q])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_b[b] = act_ok && (cmd.bank == BANK_W'(b));
        assign wr_b[b]  = wr_ok  && (cmd.bank == BANK_W'(b));
        mtc_bank #(
            .N_ROWS(N_ROWS), .COLS(COLS), .COL_BITS(COL_BITS),
            .ROW_AW(ROW_AW), .COL_AW(COL_AW)
        ) bank_i (
            .clk     (clk),
            .rst     (rst),
            .act_i   (act_b[b]),
            .row_i   (cmd_row_i),
            .wr_i    (wr_b[b]),
            .col_i   (cmd_col_i),
            .wdata_i (cmd_wdata_i),
            .open_o  (open_b[b]),
            .rdata_o (rdata_b[b])
        );
    end

    for (genvar s = 0; s < 2; s++) begin : g_lane
        assign push[s] = rd_ok && (c_lane == 1'(s));
        mtc_dq_lane #(.RD_LAT(RD_LAT), .HALF(HALF), .BEAT_W(BEAT_W)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .push_i  (push[s]),
            .upper_i (c_upper),
            .data_i  (rdata_b[cmd.bank]),
            .clash_o (clash[s]),
            .dq_o    (dq_l[s]),
            .vld_o   (vld_l[s])
        );
    end

    assign dqa_o     = dq_l[0];
    assign dqa_vld_o = vld_l[0];
    assign dqb_o     = dq_l[1];
    assign dqb_vld_o = vld_l[1];

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld_i |=> !err_o);

    assert_rsv_rejected_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld_i && cmd_op_i == 2'b11) |=> err_o);

    assert_single_push_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(push) <= 1);

endmodule

// File: tb/mtc_core_tb_top.sv
module mtc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_vld_i;
    logic [1:0]  cmd_op_i;
    logic [3:0]  cmd_bank_i;
    logic [1:0]  cmd_row_i;
    logic [0:0]  cmd_col_i;
    logic [63:0] cmd_wdata_i;
    logic        err_o;
    logic [31:0] dqa_o, dqb_o;
    logic        dqa_vld_o, dqb_vld_o;

    always #10 clk = ~clk;

    mtc_core dut_i (
        .clk(clk), .rst(rst), .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i),
        .cmd_bank_i(cmd_bank_i), .cmd_row_i(cmd_row_i), .cmd_col_i(cmd_col_i),
        .cmd_wdata_i(cmd_wdata_i), .err_o(err_o), .dqa_o(dqa_o),
        .dqa_vld_o(dqa_vld_o), .dqb_o(dqb_o), .dqb_vld_o(dqb_vld_o)
    );

    localparam logic [1:0] ACT = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

    // {exp_err, op, bank, row, col}, one command per cycle
    localparam int NV = 19;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, RD,  4'd0,  2'd0, 1'b0},  // R5 no open row
        {1'b1, RSV, 4'd0,  2'd0, 1'b0},  // R6 reserved op
        {1'b0, ACT, 4'd0,  2'd1, 1'b0},  // R3
        {1'b1, ACT, 4'd2,  2'd0, 1'b0},  // R3 same quadrant, +1
        {1'b0, ACT, 4'd1,  2'd2, 1'b0},  // R3 other quadrant free
        {1'b1, ACT, 4'd4,  2'd0, 1'b0},  // R3 same quadrant, T_RR-1
        {1'b0, ACT, 4'd2,  2'd0, 1'b0},  // R3 exact T_RR
        {1'b0, ACT, 4'd8,  2'd3, 1'b0},  // R2 upper quadrant
        {1'b0, ACT, 4'd9,  2'd0, 1'b0},
        {1'b0, WR,  4'd0,  2'd0, 1'b0},  // R10
        {1'b1, WR,  4'd2,  2'd0, 1'b0},  // R4 same quadrant, +1
        {1'b0, WR,  4'd1,  2'd0, 1'b1},  // R4 other quadrant
        {1'b0, WR,  4'd8,  2'd0, 1'b0},
        {1'b0, WR,  4'd2,  2'd0, 1'b1},  // R4 exact T_CC
        {1'b0, WR,  4'd9,  2'd0, 1'b1},
        {1'b0, WR,  4'd1,  2'd0, 1'b0},
        {1'b0, WR,  4'd8,  2'd0, 1'b1},
        {1'b0, WR,  4'd0,  2'd0, 1'b1},
        {1'b1, WR,  4'd15, 2'd0, 1'b0}   // R5 quadrant free, row closed
    };

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic        la_v [1024], lb_v [1024], le [1024];
    logic [31:0] la_d [1024], lb_d [1024];

    function automatic logic [63:0] wd(input int i);
        return {16'hC0DE, i[15:0], 16'h5A5A ^ i[15:0], 16'(i * 7 + 1)};
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        la_v[cyc % 1024] = dqa_vld_o; la_d[cyc % 1024] = dqa_o;
        lb_v[cyc % 1024] = dqb_vld_o; lb_d[cyc % 1024] = dqb_o;
        le[cyc % 1024]   = err_o;
    endtask

    task automatic idle_until(input int st);
        while (cyc < st) step();
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] b, input logic [1:0] r,
                         input logic c, input logic [63:0] d, output int k);
        cmd_vld_i = 1'b1; cmd_op_i = op; cmd_bank_i = b;
        cmd_row_i = r; cmd_col_i = c; cmd_wdata_i = d;
        k = cyc;
        step();
        cmd_vld_i = 1'b0;
    endtask

    task automatic chk_err(input int st, input logic exp, input string tag);
        n_tests++;
        if (le[st % 1024] !== exp) begin
            n_fail++;
            $display("FAIL %s: err at cycle %0d got %0b exp %0b", tag, st, le[st % 1024], exp);
        end
    endtask

    task automatic chk_lane(input bit lane, input int st, input logic ev,
                            input logic [31:0] ed, input string tag);
        logic v; logic [31:0] d;
        v = lane ? lb_v[st % 1024] : la_v[st % 1024];
        d = lane ? lb_d[st % 1024] : la_d[st % 1024];
        n_tests++;
        if (v !== ev || (ev && d !== ed)) begin
            n_fail++;
            $display("FAIL %s: lane %0d cycle %0d got vld=%0b data=%h exp vld=%0b data=%h",
                     tag, lane, st, v, d, ev, ed);
        end
    endtask

    task automatic chk_burst(input bit lane, input int st, input logic [63:0] w,
                             input string tag);
        chk_lane(lane, st,     1'b1, w[31:0],  tag);
        chk_lane(lane, st + 1, 1'b1, w[63:32], tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
    endtask

    initial begin
        int k, k2, k3;
        cmd_vld_i = 0; cmd_op_i = 0; cmd_bank_i = 0; cmd_row_i = 0;
        cmd_col_i = 0; cmd_wdata_i = 0;
        do_reset();
        // R1 reset state at the ports
        chk_err(cyc, 1'b0, "R1 reset err");
        chk_lane(0, cyc, 1'b0, 32'h0, "R1 reset lane A");
        chk_lane(1, cyc, 1'b0, 32'h0, "R1 reset lane B");

        // timing-rule table
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][8:7], VEC[i][6:3], VEC[i][2:1], VEC[i][0], wd(i), k);
            chk_err(k + 1, VEC[i][9], $sformatf("R3/R4/R5/R6 vector %0d", i));
        end
        idle_until(cyc + 6);

        // R7 lower read on lane A; R6 rejected write left bank2 col0 at zero
        issue(RD, 4'd0, 2'd0, 1'b0, 64'h0, k);
        idle_until(k + 4);
        issue(RD, 4'd2, 2'd0, 1'b0, 64'h0, k2);
        idle_until(k + 10);
        chk_err(k + 1, 1'b0, "R7 read accepted");
        chk_err(k + 2, 1'b0, "R6 one-cycle pulse only");
        chk_lane(0, k + 2, 1'b0, 32'h0, "R7 nothing before latency");
        chk_burst(0, k + 3, wd(9), "R7/R10 lane A beats");
        chk_lane(1, k + 3, 1'b0, 32'h0, "R2 lane B idle");
        chk_lane(0, k + 5, 1'b0, 32'h0, "R7 valid drops");
        chk_err(k2 + 1, 1'b0, "R4 column at exact T_CC");
        chk_burst(0, k2 + 3, 64'h0, "R6 rejected write not stored");

        // R8 interleave on lane B
        issue(RD, 4'd1, 2'd0, 1'b1, 64'h0, k);
        issue(RD, 4'd9, 2'd0, 1'b1, 64'h0, k2);
        idle_until(k + 9);
        chk_err(k + 2, 1'b0, "R8 upper read accepted");
        chk_burst(1, k + 3, wd(11), "R2/R8 lower burst lane B");
        chk_burst(1, k + 5, wd(14), "R8 upper burst follows");
        chk_lane(1, k + 7, 1'b0, 32'h0, "R8 lane idle after pair");
        chk_lane(0, k + 4, 1'b0, 32'h0, "R2 lane A idle");

        // R9 slot collision
        issue(RD, 4'd8, 2'd0, 1'b0, 64'h0, k);
        issue(RD, 4'd0, 2'd0, 1'b1, 64'h0, k2);
        issue(RSV, 4'd3, 2'd0, 1'b0, 64'h0, k3);
        issue(RD, 4'd0, 2'd0, 1'b1, 64'h0, k3);
        idle_until(k + 10);
        chk_err(k + 1, 1'b0, "R8 upper read accepted");
        chk_err(k2 + 1, 1'b1, "R9 clashing read rejected");
        chk_err(k3 + 1, 1'b0, "R9 fitting read accepted");
        chk_burst(0, k + 4, wd(12), "R8 upper latency");
        chk_burst(0, k + 6, wd(17), "R9 later read data");
        chk_lane(0, k + 8, 1'b0, 32'h0, "R9 no extra beats");

        // R11 row switch
        issue(ACT, 4'd0, 2'd2, 1'b0, 64'h0, k);
        idle_until(k + 4);
        issue(RD, 4'd0, 2'd0, 1'b0, 64'h0, k2);
        idle_until(k + 5);
        issue(ACT, 4'd0, 2'd1, 1'b0, 64'h0, k3);
        idle_until(k + 9);
        issue(RD, 4'd0, 2'd0, 1'b0, 64'h0, k3);
        idle_until(k + 15);
        chk_err(k + 1, 1'b0, "R11 reactivate accepted");
        chk_burst(0, k2 + 3, 64'h0, "R11 new row read");
        chk_burst(0, k3 + 3, wd(9), "R11 old row kept");

        // R1 second reset: rows closed, storage zero
        do_reset();
        chk_lane(0, cyc, 1'b0, 32'h0, "R1 lanes quiet after reset");
        issue(RD, 4'd1, 2'd0, 1'b1, 64'h0, k);
        issue(ACT, 4'd1, 2'd2, 1'b0, 64'h0, k2);
        issue(RD, 4'd1, 2'd0, 1'b1, 64'h0, k3);
        idle_until(k3 + 6);
        chk_err(k + 1, 1'b1, "R1 rows closed after reset");
        chk_err(k2 + 1, 1'b0, "R1 activate after reset");
        chk_err(k3 + 1, 1'b0, "R1 read after activate");
        chk_burst(1, k3 + 3, 64'h0, "R1 storage cleared");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule